// File: doc/BRIEF.md
# Segment Map Address Translator

This block turns a segmented virtual address, a segment number plus an offset, into a physical address. It keeps two register-held segment maps of sixteen entries each. One map serves supervisor-mode accesses and the other serves user-mode accesses, and a privilege input on each request picks the map. The segment number indexes the chosen map. The entry supplies a base address, a length, a valid flag, a dirty flag and read and write permissions. The physical address is the base plus the offset, computed with an adder and not by concatenation.

Each request is checked against its entry. The block reports at most one fault code per access. When several faults apply, a missing segment wins over an out-of-range offset, and an out-of-range offset wins over a permission violation. A write that translates cleanly marks its entry dirty on the same clock edge that registers the response. Software fills entries through a one-cycle load port. Fetching segments from backing store and choosing where to place them are left to software.

Top module: `seg_xlate`

## Requirements
- R1: After reset, rsp_valid is low and every entry of both maps is invalid, so any access reports a segment fault.
- R2: A request accepted while req_valid is high produces rsp_valid high exactly one cycle later. No request in a cycle means rsp_valid is low in the next cycle.
- R3: Without a fault, rsp_paddr equals the entry base plus the zero-extended offset, taken modulo 2^20. With any fault, rsp_paddr is 0.
- R4: req_super=1 selects the system map and req_super=0 selects the user map. The two maps hold independent contents for the same segment number.
- R5: An access to an entry whose valid flag is clear reports rsp_fault=1 (segment fault).
- R6: An offset greater than or equal to the entry length reports rsp_fault=2 (bounds fault). An offset of length-1 is in range.
- R7: A read to an entry with the read permission clear, or a write to an entry with the write permission clear, reports rsp_fault=3 (protection fault). A clean access reports rsp_fault=0.
- R8: Only one fault code is reported per access. Segment fault beats bounds fault, and bounds fault beats protection fault.
- R9: A write with no fault sets the entry's dirty flag, and rsp_dirty reports 1 for that access. Reads and faulted writes leave the dirty flag unchanged. rsp_dirty reports the entry's dirty flag as it stands after the access.
- R10: A load with cfg_we=1 replaces the whole entry cfg_idx of the map chosen by cfg_sys (1=system, 0=user), including its dirty flag. Requests from the next cycle on see the new entry. A load to the entry a clean write marks dirty in the same cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_super | input | 1 | 1 = supervisor (system map), 0 = user map |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_seg | input | 4 | Segment number |
| req_off | input | 16 | Offset within segment |
| rsp_valid | output | 1 | Response valid, one cycle after request |
| rsp_fault | output | 2 | 0 none, 1 segment, 2 bounds, 3 protection |
| rsp_paddr | output | 20 | Physical address, 0 on fault |
| rsp_dirty | output | 1 | Entry dirty flag after this access |
| cfg_we | input | 1 | Entry load strobe |
| cfg_sys | input | 1 | Load target: 1 system map, 0 user map |
| cfg_idx | input | 4 | Entry index to load |
| cfg_base | input | 20 | Segment base address |
| cfg_len | input | 17 | Segment length in bytes |
| cfg_valid | input | 1 | Valid flag to load |
| cfg_rd_ok | input | 1 | Read permission to load |
| cfg_wr_ok | input | 1 | Write permission to load |
| cfg_dirty | input | 1 | Dirty flag to load |

## Verification
Four properties are checked on every cycle. The response follows each request by one cycle. A faulted response carries a zero address. A missing segment or an out-of-range offset always shows up as the matching code regardless of the other conditions. Every clean write comes back with the dirty flag set. Only the directed scenarios can show the rest: the arithmetic of base plus offset including wrap-around, that the two maps stay separate, the exact boundary at the length, the persistence of the dirty flag across later reads, and a load that overrides a same-cycle dirty update.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int SEG_W = 4;
  localparam int OFF_W = 16;
  localparam int PA_W  = 20;
  localparam int LEN_W = OFF_W + 1;
  localparam int NENT  = 1 << SEG_W;
  localparam int NMAP  = 2;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_SEG  = 2'd1,
    FLT_BND  = 2'd2,
    FLT_PROT = 2'd3
  } fault_e;

  typedef struct packed {
    logic [PA_W-1:0]  base;
    logic [LEN_W-1:0] len;
    logic             vld;
    logic             dirty;
    logic             rd_ok;
    logic             wr_ok;
  } seg_ent_t;

  function automatic logic [PA_W-1:0] f_paddr(input logic [PA_W-1:0] base,
                                               input logic [OFF_W-1:0] off);
    return base + PA_W'(off);
  endfunction

  function automatic fault_e f_classify(input logic inval, input logic oob,
                                        input logic deny);
    if (inval)     return FLT_SEG;
    else if (oob)  return FLT_BND;
    else if (deny) return FLT_PROT;
    else           return FLT_NONE;
  endfunction
endpackage

// File: rtl/seg_map.sv
module seg_map
  import seg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEG_W-1:0] wr_idx,
  input  seg_ent_t         wr_ent,
  input  logic             set_en,
  input  logic [SEG_W-1:0] set_idx,
  input  logic [SEG_W-1:0] rd_idx,
  output seg_ent_t         rd_ent
);
  seg_ent_t mem [NENT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NENT; i++) mem[i] <= '0;
    end else begin
      if (set_en) mem[set_idx].dirty <= 1'b1;
      if (wr_en)  mem[wr_idx] <= wr_ent;   // load wins over dirty mark
    end
  end

  assign rd_ent = mem[rd_idx];
endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_pkg::*;
(
  input  seg_ent_t         ent,
  input  logic [OFF_W-1:0] off,
  input  logic             write,
  output logic             raw_inval,
  output logic             raw_oob,
  output logic             raw_deny,
  output fault_e           fault,
  output logic [PA_W-1:0]  paddr
);
  always_comb begin
    raw_inval = !ent.vld;
    raw_oob   = {1'b0, off} >= ent.len;
    raw_deny  = write ? !ent.wr_ok : !ent.rd_ok;
    fault     = f_classify(raw_inval, raw_oob, raw_deny);
    paddr     = f_paddr(ent.base, off);
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   req_super,
  input  logic                   req_write,
  input  logic [SEG_W-1:0]       req_seg,
  input  logic [OFF_W-1:0]       req_off,
  output logic                   rsp_valid,
  output logic [1:0]             rsp_fault,
  output logic [PA_W-1:0]        rsp_paddr,
  output logic                   rsp_dirty,
  input  logic                   cfg_we,
  input  logic                   cfg_sys,
  input  logic [SEG_W-1:0]       cfg_idx,
  input  logic [PA_W-1:0]        cfg_base,
  input  logic [LEN_W-1:0]       cfg_len,
  input  logic                   cfg_valid,
  input  logic                   cfg_rd_ok,
  input  logic                   cfg_wr_ok,
  input  logic                   cfg_dirty
);
  seg_ent_t        ent_arr [NMAP];
  seg_ent_t        ent;
  seg_ent_t        load_ent;
  fault_e          fault;
  logic [PA_W-1:0] paddr;
  logic            raw_inval, raw_oob, raw_deny;
  logic            dirty_set;

  assign load_ent = '{base: cfg_base, len: cfg_len, vld: cfg_valid,
                      dirty: cfg_dirty, rd_ok: cfg_rd_ok, wr_ok: cfg_wr_ok};

  // map 0 = user, map 1 = system
  for (genvar m = 0; m < NMAP; m++) begin : g_map
    seg_map u_map (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (cfg_we && (cfg_sys == 1'(m))),
      .wr_idx (cfg_idx),
      .wr_ent (load_ent),
      .set_en (dirty_set && (req_super == 1'(m))),
      .set_idx(req_seg),
      .rd_idx (req_seg),
      .rd_ent (ent_arr[m])
    );
  end

  assign ent = ent_arr[req_super];

  seg_check u_check (
    .ent      (ent),
    .off      (req_off),
    .write    (req_write),
    .raw_inval(raw_inval),
    .raw_oob  (raw_oob),
    .raw_deny (raw_deny),
    .fault    (fault),
    .paddr    (paddr)
  );

  assign dirty_set = req_valid && req_write && (fault == FLT_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 2'd0;
      rsp_paddr <= '0;
      rsp_dirty <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_fault <= fault;
        rsp_paddr <= (fault == FLT_NONE) ? paddr : '0;
        rsp_dirty <= ent.dirty | dirty_set;
      end
    end
  end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk
  import seg_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_write,
  input logic            rsp_valid,
  input logic [1:0]      rsp_fault,
  input logic [PA_W-1:0] rsp_paddr,
  input logic            rsp_dirty,
  input logic            raw_inval,
  input logic            raw_oob
);
  assert_rsp_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_rsp_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  assert_fault_zero_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 2'd0) |-> rsp_paddr == '0);
  assert_seg_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && raw_inval) |=> rsp_fault == 2'd1);
  assert_bound_second_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !raw_inval && raw_oob) |=> rsp_fault == 2'd2);
  assert_clean_write_dirty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |=> (rsp_fault != 2'd0 || rsp_dirty));
endmodule

bind seg_xlate seg_xlate_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_write(req_write),
  .rsp_valid(rsp_valid),
  .rsp_fault(rsp_fault),
  .rsp_paddr(rsp_paddr),
  .rsp_dirty(rsp_dirty),
  .raw_inval(raw_inval),
  .raw_oob  (raw_oob)
);

// File: tb/test_seg_xlate.sv
module test_seg_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 0, req_super = 0, req_write = 0;
  logic [3:0]  req_seg = 0;
  logic [15:0] req_off = 0;
  logic        rsp_valid, rsp_dirty;
  logic [1:0]  rsp_fault;
  logic [19:0] rsp_paddr;
  logic        cfg_we = 0, cfg_sys = 0, cfg_valid = 0, cfg_rd_ok = 0, cfg_wr_ok = 0, cfg_dirty = 0;
  logic [3:0]  cfg_idx = 0;
  logic [19:0] cfg_base = 0;
  logic [16:0] cfg_len = 0;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  logic [1:0]  f;
  logic [19:0] pa;
  logic        d;

  always #5 clk = ~clk;

  seg_xlate i_seg_xlate (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(input logic sys, input logic [3:0] idx, input logic [19:0] base,
                      input logic [16:0] len, input logic v, input logic r,
                      input logic w, input logic dt);
    @(negedge clk);
    cfg_we = 1; cfg_sys = sys; cfg_idx = idx; cfg_base = base; cfg_len = len;
    cfg_valid = v; cfg_rd_ok = r; cfg_wr_ok = w; cfg_dirty = dt;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic access(input logic sup, input logic wr, input logic [3:0] seg,
                        input logic [15:0] off);
    @(negedge clk);
    req_valid = 1; req_super = sup; req_write = wr; req_seg = seg; req_off = off;
    @(negedge clk);
    req_valid = 0;
    chk("R2 rsp_valid", 32'(rsp_valid), 1);
    f = rsp_fault; pa = rsp_paddr; d = rsp_dirty;
  endtask

  task automatic t_reset;
    chk("R1 rsp_valid after reset", 32'(rsp_valid), 0);
    access(0, 0, 4'd3, 16'h0);
    chk("R1 user entry invalid", 32'(f), 1);
    access(1, 1, 4'd0, 16'h0);
    chk("R5 system entry invalid", 32'(f), 1);
    chk("R3 fault addr zero", 32'(pa), 0);
    @(negedge clk);
    chk("R2 idle no response", 32'(rsp_valid), 0);
  endtask

  task automatic t_translate;
    load(0, 4'd2, 20'h12340, 17'h1000, 1, 1, 1, 0);
    access(0, 0, 4'd2, 16'h0010);
    chk("R7 clean read code", 32'(f), 0);
    chk("R3 base plus offset", 32'(pa), 32'h12350);
    load(0, 4'd5, 20'hFFFF0, 17'h10000, 1, 1, 1, 0);
    access(0, 0, 4'd5, 16'h0020);
    chk("R3 wrap modulo", 32'(pa), 32'h00010);
    access(0, 0, 4'd5, 16'hFFFF);
    chk("R6 max offset in range", 32'(f), 0);
    chk("R3 max offset sum", 32'(pa), 32'h0FFEF);
  endtask

  task automatic t_maps;
    load(1, 4'd2, 20'h40000, 17'h0100, 1, 1, 0, 0);
    access(1, 0, 4'd2, 16'h0004);
    chk("R4 system map base", 32'(pa), 32'h40004);
    access(0, 0, 4'd2, 16'h0004);
    chk("R4 user map base", 32'(pa), 32'h12344);
    access(1, 0, 4'd5, 16'h0);
    chk("R4 system seg5 separate", 32'(f), 1);
  endtask

  task automatic t_bound;
    access(1, 0, 4'd2, 16'h00FF);
    chk("R6 length-1 ok", 32'(f), 0);
    access(1, 0, 4'd2, 16'h0100);
    chk("R6 length faults", 32'(f), 2);
    chk("R3 bounds addr zero", 32'(pa), 0);
  endtask

  task automatic t_prot;
    access(1, 1, 4'd2, 16'h0010);
    chk("R7 write to read-only", 32'(f), 3);
    load(0, 4'd7, 20'h00800, 17'h0040, 1, 0, 1, 0);
    access(0, 0, 4'd7, 16'h0010);
    chk("R7 read to write-only", 32'(f), 3);
    access(0, 1, 4'd7, 16'h0010);
    chk("R7 write to write-only", 32'(f), 0);
  endtask

  task automatic t_prio;
    load(0, 4'd9, 20'h00100, 17'h0010, 0, 0, 0, 0);
    access(0, 1, 4'd9, 16'h0020);
    chk("R8 seg over bound/prot", 32'(f), 1);
    load(0, 4'd9, 20'h00100, 17'h0010, 1, 0, 0, 0);
    access(0, 1, 4'd9, 16'h0020);
    chk("R8 bound over prot", 32'(f), 2);
  endtask

  task automatic t_dirty;
    load(0, 4'd4, 20'h20000, 17'h0100, 1, 1, 1, 0);
    access(0, 0, 4'd4, 16'h0001);
    chk("R9 read leaves clean", 32'(d), 0);
    access(0, 1, 4'd4, 16'h0200);
    chk("R9 faulted write code", 32'(f), 2);
    access(0, 0, 4'd4, 16'h0001);
    chk("R9 faulted write leaves clean", 32'(d), 0);
    access(0, 1, 4'd4, 16'h0002);
    chk("R9 clean write dirty", 32'(d), 1);
    access(0, 0, 4'd4, 16'h0001);
    chk("R9 dirty persists", 32'(d), 1);
    access(1, 0, 4'd4, 16'h0);
    chk("R4 system entry untouched", 32'(f), 1);
    load(0, 4'd4, 20'h20000, 17'h0100, 1, 1, 1, 0);
    access(0, 0, 4'd4, 16'h0001);
    chk("R10 load clears dirty", 32'(d), 0);
  endtask

  task automatic t_collide;
    @(negedge clk);
    req_valid = 1; req_super = 0; req_write = 1; req_seg = 4'd4; req_off = 16'h3;
    cfg_we = 1; cfg_sys = 0; cfg_idx = 4'd4; cfg_base = 20'h30000; cfg_len = 17'h0100;
    cfg_valid = 1; cfg_rd_ok = 1; cfg_wr_ok = 1; cfg_dirty = 0;
    @(negedge clk);
    req_valid = 0; cfg_we = 0;
    chk("R10 old entry used that cycle", 32'(rsp_paddr), 32'h20003);
    access(0, 0, 4'd4, 16'h0003);
    chk("R10 load wins over dirty", 32'(d), 0);
    chk("R10 new base next cycle", 32'(pa), 32'h30003);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_translate();
    t_maps();
    t_bound();
    t_prot();
    t_prio();
    t_dirty();
    t_collide();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule